// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running tick count and a compare value, and asks for a software interrupt when the count catches up with the compare value. The count advances by one on each cycle in which the tick strobe is high. The strobe is normally derived from a 100 MHz time base; converting from wall-clock time is left to the logic that produces the strobe. Software reaches the block through a register-style port. One select bit picks the count word or the compare word, both for writes and for the combinational read.

Bit 63 of both words is a stop flag, and its position is the parameter `DIS_BIT`. There is a single flag shared by both words. Writing either word loads the flag from that bit and stores the remaining bits. Reading either word returns the stored bits, with the flag bit forced on while the timer is stopped. Each write of the compare word arms at most one expiry. A compare value of zero arms nothing. A compare write with the stop flag set also arms nothing. A compare value that is already behind the count expires on the very next tick.

The write and read ports are plain register strobes with no back-pressure. A write takes effect at the clock edge where `wr_en` is high, and the read data follows the select and the stored state combinationally.

Top module: `tick_cmp_top`

## Requirements
- R1: After reset the timer is stopped, no expiry is armed, both words read 0x8000_0000_0000_0000 and `soft_irq` is low.
- R2: A write with `wr_sel`=0 stores the data with bit 63 cleared as the count, and sets the stop flag to data bit 63.
- R3: A read with `rd_sel`=0 returns the count, with bit 63 set exactly when the timer is stopped.
- R4: Each cycle with `tick_en` high and no count write adds one to the count. A cycle with neither a strobe nor a count write leaves the count unchanged.
- R5: A write with `wr_sel`=1 stores the data with bit 63 cleared as the compare value and sets the stop flag to data bit 63. A read with `rd_sel`=1 returns that value, with bit 63 set while stopped.
- R6: While a compare value is armed, a tick that brings the count to or past it is an expiry. If the timer is running at that moment, `soft_irq` is high for exactly the one cycle after that clock edge.
- R7: An expiry disarms the compare, so later ticks raise nothing until the compare word is written again.
- R8: A compare write whose low 63 bits are zero arms nothing, and no pulse follows however many ticks occur.
- R9: A compare write with bit 63 set cancels any armed expiry and arms nothing. Restarting the timer later with a count write raises no pulse.
- R10: A compare value equal to or below the current count, written while running, raises `soft_irq` on the next tick.
- R11: An armed expiry that is reached while the timer is stopped (stopped through a count write) raises nothing and is consumed. Restarting the timer afterwards raises no pulse.
- R12: In a cycle with both a write and a tick, no expiry is evaluated. A count write takes its written value and drops that tick. A compare write leaves that tick counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe, one increment per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 compare |
| wr_data | input | 64 | Write data, bit 63 is the stop flag |
| rd_sel | input | 1 | Read source: 0 count, 1 compare |
| rd_data | output | 64 | Read data with the stop flag ORed into bit 63 |
| soft_irq | output | 1 | One-cycle software-interrupt set pulse |

## Verification
The tick strobe and a register write can fall in the same cycle, and the block's behaviour in that cycle is the riskiest. The bench raises `tick_en` together with a count write placed one tick before an armed expiry. It checks that the written count replaces the tick and that no pulse appears. It then raises the strobe together with a compare write and checks that the count still advanced, by counting the exact number of further ticks until the single pulse.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } tc_sel_e;
endpackage

// File: rtl/tc_count.sv
module tc_count #(
  parameter int W       = 64,
  parameter int DIS_BIT = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_next
);
  localparam logic [W-1:0] MASK = {{(W-1){1'b0}}, 1'b1} << DIS_BIT;

  assign cnt_next = (cnt_q + {{(W-1){1'b0}}, 1'b1}) & ~MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val & ~MASK;
    else if (tick_en) cnt_q <= cnt_next;
  end

  // R2 R12
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == ($past(load_val) & ~MASK));
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load) |=> cnt_q == (($past(cnt_q) + 1'b1) & ~MASK));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/tc_limit.sv
module tc_limit #(
  parameter int W       = 64,
  parameter int DIS_BIT = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         any_wr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cnt_next,
  output logic [W-1:0] lim_q,
  output logic         armed_q,
  output logic         expire
);
  localparam logic [W-1:0] MASK = {{(W-1){1'b0}}, 1'b1} << DIS_BIT;

  logic [W-1:0] new_lim;
  logic         new_arm;

  assign new_lim = load_val & ~MASK;
  assign new_arm = (new_lim != '0) && !load_val[DIS_BIT];
  assign expire  = tick_en && !any_wr && armed_q && (cnt_next >= lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      lim_q   <= new_lim;
      armed_q <= new_arm;
    end else if (expire) begin
      armed_q <= 1'b0;
    end
  end

  // R8
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ((load_val & ~MASK) == '0)) |=> !armed_q);
  // R9
  stopped_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val[DIS_BIT]) |=> !armed_q);
  // R7
  once_per_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed_q);
  // R12
  write_blocks_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |-> !expire);
endmodule

// File: rtl/tc_flag.sv
module tc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_load,
  input  logic flag_val,
  input  logic expire,
  output logic dis_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      if (flag_load) dis_q <= flag_val;
      irq_q <= expire && !dis_q;
    end
  end

  // R6 R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !$past(dis_q));
  // R2 R5
  flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> dis_q == $past(flag_val));
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/tick_cmp_top.sv
module tick_cmp_top
  import tick_cmp_pkg::*;
#(
  parameter int W       = 64,
  parameter int DIS_BIT = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         soft_irq
);
  localparam logic [W-1:0] MASK = {{(W-1){1'b0}}, 1'b1} << DIS_BIT;

  tc_sel_e      wsel, rsel;
  logic         cnt_wr, lim_wr;
  logic [W-1:0] cnt_q, cnt_next, lim_q;
  logic         armed_q, expire, dis_q;

  assign wsel   = tc_sel_e'(wr_sel);
  assign rsel   = tc_sel_e'(rd_sel);
  assign cnt_wr = wr_en && (wsel == SEL_COUNT);
  assign lim_wr = wr_en && (wsel == SEL_LIMIT);

  tc_count #(.W(W), .DIS_BIT(DIS_BIT)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load(cnt_wr), .load_val(wr_data),
    .cnt_q(cnt_q), .cnt_next(cnt_next)
  );

  tc_limit #(.W(W), .DIS_BIT(DIS_BIT)) u_limit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .any_wr(wr_en),
    .load(lim_wr), .load_val(wr_data), .cnt_next(cnt_next),
    .lim_q(lim_q), .armed_q(armed_q), .expire(expire)
  );

  tc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .flag_load(wr_en),
    .flag_val(wr_data[DIS_BIT]), .expire(expire),
    .dis_q(dis_q), .irq_q(soft_irq)
  );

  always_comb begin
    rd_data = (rsel == SEL_LIMIT) ? lim_q : cnt_q;
    if (dis_q) rd_data = rd_data | MASK;
  end

  // R3 R5
  read_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DIS_BIT] == dis_q);
  // R10
  irq_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_irq |-> $past(armed_q));
endmodule

// File: tb/sim_tick_cmp_top.sv
module sim_tick_cmp_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] M = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        soft_irq;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_cmp_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .soft_irq(soft_irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic we, input logic sel, input logic [63:0] d);
    tick_en = tk; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  // tick n times; pulse expected only after tick number fire_at (0 = never)
  task automatic ticks(input string tag, input int n, input int fire_at);
    for (int i = 1; i <= n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, '0);
      check(tag, {63'd0, soft_irq}, {63'd0, i == fire_at});
    end
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(1'b0, v); check("R1 count", v, M);
    rd(1'b1, v); check("R1 limit", v, M);
    check("R1 irq", {63'd0, soft_irq}, '0);
  endtask

  task automatic t_count_rw;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_1234);
    rd(1'b0, v); check("R2 R3 running count", v, 64'h1234);
    cyc(1'b0, 1'b1, 1'b0, 64'h8000_0000_0000_0055);
    rd(1'b0, v); check("R2 R3 stopped count", v, 64'h8000_0000_0000_0055);
    cyc(1'b0, 1'b1, 1'b0, 64'h7fff_0000_0000_00aa);
    rd(1'b0, v); check("R2 high bits kept", v, 64'h7fff_0000_0000_00aa);
  endtask

  task automatic t_tick;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 1'b0, 64'd10);
    ticks("R4 no irq", 5, 0);
    rd(1'b0, v); check("R4 five ticks", v, 64'd15);
    cyc(1'b0, 1'b0, 1'b0, '0); cyc(1'b0, 1'b0, 1'b0, '0);
    rd(1'b0, v); check("R4 hold", v, 64'd15);
  endtask

  task automatic t_limit_rw;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 1'b1, M | 64'h20);
    rd(1'b1, v); check("R5 stopped limit", v, M | 64'h20);
    rd(1'b0, v); check("R5 flag on count", v, M | 64'd15);
    cyc(1'b0, 1'b1, 1'b1, 64'h20);
    rd(1'b1, v); check("R5 running limit", v, 64'h20);
  endtask

  task automatic t_expiry;
    cyc(1'b0, 1'b1, 1'b0, 64'd100);
    cyc(1'b0, 1'b1, 1'b1, 64'd105);
    ticks("R6 pulse at 105", 6, 5);
    ticks("R7 no second pulse", 8, 0);
  endtask

  task automatic t_zero;
    cyc(1'b0, 1'b1, 1'b0, 64'd0);
    cyc(1'b0, 1'b1, 1'b1, 64'd0);
    ticks("R8 zero limit", 6, 0);
  endtask

  task automatic t_stopped_limit;
    cyc(1'b0, 1'b1, 1'b0, 64'd50);
    cyc(1'b0, 1'b1, 1'b1, 64'd60);
    cyc(1'b0, 1'b1, 1'b1, M | 64'd55);
    ticks("R9 stopped limit", 10, 0);
    cyc(1'b0, 1'b1, 1'b0, 64'd50);
    ticks("R9 restart", 12, 0);
  endtask

  task automatic t_past_due;
    cyc(1'b0, 1'b1, 1'b0, 64'd200);
    cyc(1'b0, 1'b1, 1'b1, 64'd150);
    ticks("R10 behind", 3, 1);
    cyc(1'b0, 1'b1, 1'b0, 64'd300);
    cyc(1'b0, 1'b1, 1'b1, 64'd300);
    ticks("R10 equal", 3, 1);
  endtask

  task automatic t_stop_at_expiry;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 1'b0, 64'd0);
    cyc(1'b0, 1'b1, 1'b1, 64'd3);
    cyc(1'b0, 1'b1, 1'b0, M);
    ticks("R11 stopped expiry", 5, 0);
    rd(1'b0, v); check("R11 count runs while stopped", v, M | 64'd5);
    cyc(1'b0, 1'b1, 1'b0, 64'd0);
    ticks("R11 consumed", 6, 0);
  endtask

  task automatic t_collide;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 1'b0, 64'd10);
    cyc(1'b0, 1'b1, 1'b1, 64'd11);
    cyc(1'b1, 1'b1, 1'b0, 64'd5);
    check("R12 no irq on write cycle", {63'd0, soft_irq}, '0);
    rd(1'b0, v); check("R12 count write wins", v, 64'd5);
    ticks("R12 later expiry", 7, 6);
    cyc(1'b0, 1'b1, 1'b0, 64'd40);
    cyc(1'b1, 1'b1, 1'b1, 64'd45);
    rd(1'b0, v); check("R12 limit write keeps tick", v, 64'd41);
    ticks("R12 pulse after four", 5, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_rw();
    t_tick();
    t_limit_rw();
    t_expiry();
    t_zero();
    t_stopped_limit();
    t_past_due();
    t_stop_at_expiry();
    t_collide();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule